// File: doc/BRIEF.md
# Probabilistic replication filter

This block makes the local-replica decision at the moment a first-level cache evicts a line that the local second-level bank does not hold. A line is a candidate only when it is shared and clean. For a candidate, an internal pseudo-random value is compared against a threshold picked from a six-step level table. The replica is made when the value falls below that threshold. The same value is also compared against the thresholds of the two neighbouring levels. Those two shadow answers say what a slightly more or slightly less eager policy would have chosen, and the monitors that tune the level use them.

Each eviction strobe is one invocation. A two-state machine owns the output timing. `ST_IDLE` moves to `ST_REPORT` on a strobe. `ST_REPORT` stays in `ST_REPORT` on a back-to-back strobe and returns to `ST_IDLE` when there is no strobe. The decisions appear only while the machine is in `ST_REPORT`.

A small per-line helper keeps the shared and clean state of one tag entry. This state is what the cache presents to the filter on eviction. Generator taps are x^8 + x^6 + x^5 + x^4 + 1.

Top module: `repl_filter_top`

## Requirements
- R1: The random source is an 8-bit shift register with seed parameter `SEED` (default 8'hA5). On each strobe cycle it shifts left, and the new bit 0 is the XOR of bits 7, 5, 4 and 3. It holds its value in every cycle without a strobe and is never zero.
- R2: The level-to-threshold table is 0→0, 1→4, 2→16, 3→64, 4→128, 5→256. Level inputs 6 and 7 are treated as level 5.
- R3: `repl_now` is 1 exactly when the line is a candidate and the register value held before the strobe edge is less than the threshold of the current level.
- R4: A line is a candidate only with `blk_shared`=1 and `blk_dirty`=0. For any other line, all three decision outputs are 0. The register still advances on that strobe.
- R5: `shadow_up` applies the same value to the threshold of the level one higher. At level 5 it equals `repl_now`.
- R6: `shadow_dn` applies the same value to the threshold of the level one lower. At level 0 it is 0.
- R7: Within one result, `shadow_dn` implies `repl_now`, and `repl_now` implies `shadow_up`.
- R8: `out_vld` is 1 in the cycle after each strobe cycle and 0 otherwise. The three decisions are 0 whenever `out_vld` is 0. After reset, all outputs are 0.
- R9: In the helper, a fill records the owner id and clears both the shared and dirty flags. A request from a different id sets the shared flag. A write sets the dirty flag. Both flags persist until the next fill. A fill wins over a request in the same cycle. Updates are visible one cycle later.
- R10: Level 0 never replicates. Level 5 always replicates a candidate. Over 255 consecutive candidate evictions at level 1, exactly 3 are replicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evict_vld | input | 1 | Eviction strobe, one invocation per cycle |
| repl_level | input | 3 | Current replication level |
| blk_shared | input | 1 | Shared flag of the evicted line |
| blk_dirty | input | 1 | Dirty flag of the evicted line |
| out_vld | output | 1 | Result valid |
| repl_now | output | 1 | Make a local replica |
| shadow_up | output | 1 | Would replicate at the next higher level |
| shadow_dn | output | 1 | Would replicate at the next lower level |
| trk_fill | input | 1 | Helper: line allocated |
| trk_fill_id | input | ID_W | Helper: id of the allocating processor |
| trk_req_vld | input | 1 | Helper: request to the line |
| trk_req_id | input | ID_W | Helper: requesting processor id |
| trk_req_wr | input | 1 | Helper: request is a write |
| trk_shared | output | 1 | Helper: shared flag |
| trk_dirty | output | 1 | Helper: dirty flag |

## Verification
The three decisions and `out_vld` appear one clock edge after the strobe cycle. The random register advances on that same edge, so each result uses the value held just before it. The bench drives each strobe on a falling edge and samples at the next falling edge, which is one rising edge later. In that same sampling step it advances its own copy of the generator. The helper flags likewise change one edge after a fill or request, and they are read at the following falling edge. After every idle stretch, the next eviction result is compared against a model that did not advance, which shows the register held still.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int LVL_W   = 3;
    localparam int NUM_LVL = 6;
    localparam int MAX_LVL = NUM_LVL - 1;
    localparam int BASE_W  = 9;

    typedef enum logic {
        ST_IDLE,
        ST_REPORT
    } rf_state_e;

    // Level to threshold for an 8-bit random source.
    function automatic logic [BASE_W-1:0] base_thr(input logic [LVL_W-1:0] lvl);
        logic [BASE_W-1:0] t;
        unique case (lvl)
            3'd0:    t = 9'd0;
            3'd1:    t = 9'd4;
            3'd2:    t = 9'd16;
            3'd3:    t = 9'd64;
            3'd4:    t = 9'd128;
            default: t = 9'd256;
        endcase
        return t;
    endfunction
endpackage

// File: rtl/rf_lfsr.sv
module rf_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] SEED = 8'hA5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] q
);
    logic fb;

    generate
        if (W == 16) begin : g_taps16
            assign fb = q[15] ^ q[14] ^ q[12] ^ q[3];
        end else begin : g_taps8
            assign fb = q[7] ^ q[5] ^ q[4] ^ q[3];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= SEED;
        else if (adv)
            q <= {q[W-2:0], fb};
    end

    assert_lfsr_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0);

    assert_lfsr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(q));
endmodule

// File: rtl/rf_thresh_lut.sv
module rf_thresh_lut
    import rf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [LVL_W-1:0] lvl,
    output logic [W:0]       thr
);
    logic [LVL_W-1:0] lvl_c;

    always_comb begin
        lvl_c = (lvl > LVL_W'(MAX_LVL)) ? LVL_W'(MAX_LVL) : lvl;
        thr   = (W+1)'(base_thr(lvl_c)) << (W - 8);
    end
endmodule

// File: rtl/rf_share_track.sv
module rf_share_track #(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fill,
    input  logic [ID_W-1:0] fill_id,
    input  logic            req_vld,
    input  logic [ID_W-1:0] req_id,
    input  logic            req_wr,
    output logic            shared,
    output logic            dirty
);
    logic [ID_W-1:0] owner_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
            shared  <= 1'b0;
            dirty   <= 1'b0;
        end else if (fill) begin
            owner_q <= fill_id;
            shared  <= 1'b0;
            dirty   <= 1'b0;
        end else if (req_vld) begin
            if (req_id != owner_q)
                shared <= 1'b1;
            if (req_wr)
                dirty <= 1'b1;
        end
    end

    assert_shared_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shared && !fill |=> shared);

    assert_dirty_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dirty && !fill |=> dirty);

    assert_fill_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill |=> !shared && !dirty);
endmodule

// File: rtl/repl_filter_top.sv
module repl_filter_top
    import rf_pkg::*;
#(
    parameter int             RND_W = 8,
    parameter logic [RND_W-1:0] SEED  = 8'hA5,
    parameter int             ID_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evict_vld,
    input  logic [LVL_W-1:0] repl_level,
    input  logic             blk_shared,
    input  logic             blk_dirty,
    output logic             out_vld,
    output logic             repl_now,
    output logic             shadow_up,
    output logic             shadow_dn,
    input  logic             trk_fill,
    input  logic [ID_W-1:0]  trk_fill_id,
    input  logic             trk_req_vld,
    input  logic [ID_W-1:0]  trk_req_id,
    input  logic             trk_req_wr,
    output logic             trk_shared,
    output logic             trk_dirty
);
    localparam int THR_W  = RND_W + 1;
    localparam int N_SLOT = 3;   // 0: current, 1: higher, 2: lower

    rf_state_e         state_q, state_d;
    logic [RND_W-1:0]  rnd;
    logic [LVL_W-1:0]  lvl_c;
    logic [LVL_W-1:0]  slot_lvl [N_SLOT];
    logic [THR_W-1:0]  slot_thr [N_SLOT];
    logic [N_SLOT-1:0] hit;
    logic              eligible;

    rf_lfsr #(.W(RND_W), .SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (evict_vld),
        .q     (rnd)
    );

    always_comb begin
        lvl_c       = (repl_level > LVL_W'(MAX_LVL)) ? LVL_W'(MAX_LVL) : repl_level;
        slot_lvl[0] = lvl_c;
        slot_lvl[1] = (lvl_c == LVL_W'(MAX_LVL)) ? lvl_c : lvl_c + 1'b1;
        slot_lvl[2] = (lvl_c == '0) ? lvl_c : lvl_c - 1'b1;
        eligible    = blk_shared && !blk_dirty;
    end

    generate
        for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
            rf_thresh_lut #(.W(RND_W)) u_lut (
                .lvl (slot_lvl[s]),
                .thr (slot_thr[s])
            );
            assign hit[s] = eligible && ({1'b0, rnd} < slot_thr[s]);
        end
    endgenerate

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state: a strobe always leads to a report cycle
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = evict_vld ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = evict_vld ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n || !evict_vld) begin
            repl_now  <= 1'b0;
            shadow_up <= 1'b0;
            shadow_dn <= 1'b0;
        end else begin
            repl_now  <= hit[0];
            shadow_up <= hit[1];
            shadow_dn <= hit[2] && (lvl_c != '0);
        end
    end

    assign out_vld = (state_q == ST_REPORT);

    rf_share_track #(.ID_W(ID_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .fill    (trk_fill),
        .fill_id (trk_fill_id),
        .req_vld (trk_req_vld),
        .req_id  (trk_req_id),
        .req_wr  (trk_req_wr),
        .shared  (trk_shared),
        .dirty   (trk_dirty)
    );

    assert_vld_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evict_vld |=> out_vld);

    assert_no_vld_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !evict_vld |=> !out_vld);

    assert_quiet_when_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> !(repl_now || shadow_up || shadow_dn));

    assert_up_covers_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
        repl_now |-> shadow_up);

    assert_now_covers_dn_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_dn |-> repl_now);

    assert_ineligible_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evict_vld && (!blk_shared || blk_dirty) |=> !(repl_now || shadow_up || shadow_dn));

    assert_level0_never_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evict_vld && repl_level == '0 |=> !repl_now && !shadow_dn);

    assert_level5_always_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evict_vld && repl_level >= LVL_W'(MAX_LVL) && blk_shared && !blk_dirty |=> repl_now && shadow_up);
endmodule

// File: tb/test_repl_filter_top.sv
`timescale 1ns/1ps
module test_repl_filter_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evict_vld = 1'b0;
    logic [2:0] repl_level = '0;
    logic       blk_shared = 1'b0;
    logic       blk_dirty = 1'b0;
    logic       out_vld, repl_now, shadow_up, shadow_dn;
    logic       trk_fill = 1'b0;
    logic [2:0] trk_fill_id = '0;
    logic       trk_req_vld = 1'b0;
    logic [2:0] trk_req_id = '0;
    logic       trk_req_wr = 1'b0;
    logic       trk_shared, trk_dirty;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] m_lfsr = 8'hA5;
    int thr_tab [6] = '{0, 4, 16, 64, 128, 256};

    always #2.5 clk = ~clk;

    repl_filter_top i_repl_filter_top (
        .clk(clk), .rst_n(rst_n), .evict_vld(evict_vld), .repl_level(repl_level),
        .blk_shared(blk_shared), .blk_dirty(blk_dirty), .out_vld(out_vld),
        .repl_now(repl_now), .shadow_up(shadow_up), .shadow_dn(shadow_dn),
        .trk_fill(trk_fill), .trk_fill_id(trk_fill_id), .trk_req_vld(trk_req_vld),
        .trk_req_id(trk_req_id), .trk_req_wr(trk_req_wr),
        .trk_shared(trk_shared), .trk_dirty(trk_dirty)
    );

    task automatic check(input int act, input int exp, input string req, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // One eviction; checks the result one edge later (R3..R8)
    task automatic evict(input int lvl, input bit sh, input bit dt, input string req,
                         output bit got_now);
        int cl, up, dn, rnd;
        bit elig;
        repl_level = 3'(lvl); blk_shared = sh; blk_dirty = dt; evict_vld = 1'b1;
        @(negedge clk);
        evict_vld = 1'b0;
        cl   = (lvl > 5) ? 5 : lvl;
        up   = (cl == 5) ? 5 : cl + 1;
        dn   = (cl == 0) ? 0 : cl - 1;
        elig = sh && !dt;
        rnd  = int'(m_lfsr);
        m_lfsr = {m_lfsr[6:0], m_lfsr[7] ^ m_lfsr[5] ^ m_lfsr[4] ^ m_lfsr[3]};
        check(int'(out_vld), 1, "R8", "out_vld after strobe");
        check(int'(repl_now), int'(elig && rnd < thr_tab[cl]), req, "repl_now");
        check(int'(shadow_up), int'(elig && rnd < thr_tab[up]), "R5", "shadow_up");
        check(int'(shadow_dn), int'(elig && cl > 0 && rnd < thr_tab[dn]), "R6", "shadow_dn");
        got_now = repl_now;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(int'(out_vld), 0, "R8", "out_vld idle");
            check(int'(repl_now | shadow_up | shadow_dn), 0, "R8", "decisions idle");
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(int'(out_vld), 0, "R8", "reset out_vld");
        check(int'(repl_now | shadow_up | shadow_dn), 0, "R8", "reset decisions");
        check(int'(trk_shared | trk_dirty), 0, "R9", "reset helper");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_level_sweep();
        bit g;
        for (int l = 0; l < 8; l++)
            for (int k = 0; k < 40; k++)
                evict(l, 1'b1, 1'b0, (l > 5) ? "R2" : "R3", g);
    endtask

    task automatic t_ineligible();
        bit g;
        for (int k = 0; k < 10; k++) begin
            evict(5, 1'b0, 1'b0, "R4", g);
            evict(5, 1'b1, 1'b1, "R4", g);
            evict(3, 1'b0, 1'b1, "R4", g);
        end
        evict(4, 1'b1, 1'b0, "R4", g);   // register advanced through the above
    endtask

    task automatic t_hold();
        bit g;
        evict(3, 1'b1, 1'b0, "R1", g);
        idle_cycles(4);
        for (int k = 0; k < 8; k++) evict(3, 1'b1, 1'b0, "R1", g);
    endtask

    task automatic t_extremes();
        bit g;
        int cnt = 0;
        for (int k = 0; k < 20; k++) begin
            evict(0, 1'b1, 1'b0, "R10", g);
            check(int'(g), 0, "R10", "level 0 replicates");
            evict(5, 1'b1, 1'b0, "R10", g);
            check(int'(g), 1, "R10", "level 5 replicates");
        end
        for (int k = 0; k < 255; k++) begin
            evict(1, 1'b1, 1'b0, "R10", g);
            cnt += int'(g);
        end
        check(cnt, 3, "R10", "level 1 replications per period");
    endtask

    task automatic t_track();
        trk_fill = 1'b1; trk_fill_id = 3'd2;
        @(negedge clk); trk_fill = 1'b0;
        check(int'(trk_shared), 0, "R9", "fill clears shared");
        check(int'(trk_dirty), 0, "R9", "fill clears dirty");
        trk_req_vld = 1'b1; trk_req_id = 3'd2; trk_req_wr = 1'b0;
        @(negedge clk);
        check(int'(trk_shared), 0, "R9", "owner request keeps unshared");
        trk_req_id = 3'd5;
        @(negedge clk); trk_req_vld = 1'b0;
        check(int'(trk_shared), 1, "R9", "other id sets shared");
        check(int'(trk_dirty), 0, "R9", "read keeps clean");
        @(negedge clk);
        check(int'(trk_shared), 1, "R9", "shared sticky");
        trk_req_vld = 1'b1; trk_req_id = 3'd2; trk_req_wr = 1'b1;
        @(negedge clk); trk_req_vld = 1'b0; trk_req_wr = 1'b0;
        check(int'(trk_dirty), 1, "R9", "write sets dirty");
        check(int'(trk_shared), 1, "R9", "shared after write");
        trk_fill = 1'b1; trk_fill_id = 3'd1;
        trk_req_vld = 1'b1; trk_req_id = 3'd6; trk_req_wr = 1'b1;
        @(negedge clk);
        trk_fill = 1'b0; trk_req_vld = 1'b0; trk_req_wr = 1'b0;
        check(int'(trk_shared), 0, "R9", "fill wins shared");
        check(int'(trk_dirty), 0, "R9", "fill wins dirty");
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_level_sweep();
        t_ineligible();
        t_hold();
        t_extremes();
        t_track();
        idle_cycles(2);
        summary();
    end
endmodule